// File: doc/BRIEF.md
# Local Interrupt Timer with Vector-Entry Masking

This block is a programmable down-counting timer for a per-core interrupt controller. Software programs an initial count, a divide setting and a timer vector entry through a simple register write port. The counter then decrements once per divided clock tick. When it expires it raises an interrupt request that carries the programmed vector, and it either reloads (periodic) or stops at zero (one-shot).

The block also holds the software-enable register of the controller. That register governs the mask bit of every local vector entry, not only the timer's own entry. If an expiry occurs while an earlier timer request is still waiting for acknowledge, the expiry is not lost. It is counted, and each acknowledge re-presents the request until the count is used up.

Top module: `lt_timer`

## Requirements
- R1: Register selects are 0 for the initial count, 1 for the current count (read only), 2 for the divide setting, 3 for the enable register, and 4+i for vector entry i (entry 0 is the timer). After reset every entry reads 0x0001_0000 (mask bit 16 set), the enable register reads 0x0FF, the current count reads 0 and req_valid is low.
- R2: The divide ratio is 2 raised to (({cfg[3],cfg[1],cfg[0]} + 1) mod 8). Bit 2 of the setting is dropped and reads 0. Codes 111, 000, 011 and 100 give ratios 1, 2, 16 and 32.
- R3: Writing N to the initial count loads the current count with N at the same edge and restarts the prescaler. The first decrement follows one full divided period later.
- R4: With timer entry bit 17 set (periodic), the tick that would take the count from 1 to 0 instead reloads it from the initial count and makes a request. Requests are then N times the divide ratio edges apart.
- R5: With bit 17 clear (one-shot), that tick leaves the count at 0, where it stays, after a single request.
- R6: req_valid rises at the edge of an expiry, with req_vector equal to timer entry bits 7:0. It stays high until ack is sampled high.
- R7: An expiry while req_valid is high increments a saturating pending counter. An ack while the counter is nonzero decrements it and keeps req_valid high. An ack while the counter is zero drops req_valid.
- R8: No request is made when, at the expiry, the timer entry mask bit 16 is set or enable bit 8 is clear. Counting continues regardless.
- R9: The timer entry keeps bits 7:0, 12, 16 and 17. The other entries keep bits 10:0, 12 and 16. All other bits read 0.
- R10: The enable register keeps bits 8:0. Any write with bit 8 clear sets bit 16 in every entry. While bit 8 is clear, every entry write has bit 16 forced to 1. Setting bit 8 unmasks no entry.
- R11: Writing 0 to the initial count stops the counter with no request, and a stopped counter stays at 0.
- R12: Writing the divide setting clears the prescaler phase, so the next tick comes one full divided period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | SEL_W | Register select for the combinational read |
| rd_data | output | 32 | Read data for rd_sel |
| ack | input | 1 | Acknowledge of the timer request |
| req_valid | output | 1 | Timer interrupt request |
| req_vector | output | 8 | Vector of the outstanding request |

## Verification
A wrong prescaler phase or divide decode moves the current-count readback by one count within a single divided period after the initial-count write. It also shifts the request edge by whole ticks, so the scoreboard catches it at the first expiry. A lost or stuck pending counter shows only after acknowledges: req_valid either falls one acknowledge too early or never falls. A mask entry left clear after a disable write is visible on the next read of any entry, and on the next expiry as a request that should not occur.

// File: rtl/lt_pkg.sv
package lt_pkg;
   localparam int REG_W     = 32;
   localparam int VEC_W     = 8;
   localparam int DIVCFG_W  = 4;
   localparam int SHIFT_W   = 3;
   localparam int ENA_W     = 9;
   localparam int ENA_BIT   = 8;
   localparam int MASK_BIT  = 16;
   localparam int PER_BIT   = 17;
   localparam int SEL_INIT  = 0;
   localparam int SEL_CUR   = 1;
   localparam int SEL_DIV   = 2;
   localparam int SEL_ENA   = 3;
   localparam int LVT_BASE  = 4;
   localparam logic [REG_W-1:0] TMR_KEEP  = 32'h0003_10FF;
   localparam logic [REG_W-1:0] OTH_KEEP  = 32'h0001_17FF;
   localparam logic [REG_W-1:0] MASK_ONLY = 32'h0001_0000;
   localparam logic [DIVCFG_W-1:0] DIV_KEEP = 4'hB;

   function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIVCFG_W-1:0] cfg);
      return SHIFT_W'({cfg[3], cfg[1:0]}) + SHIFT_W'(1);
   endfunction
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
   parameter int SHIFT_W = 3,
   localparam int PRESC_W = (1 << SHIFT_W) - 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   logic [PRESC_W-1:0] phase_q;
   logic [PRESC_W-1:0] lim;

   generate
      if (PRESC_W < 1) begin : g_bad
         $error("lt_prescaler: SHIFT_W too small");
      end
   endgenerate

   assign lim  = PRESC_W'((64'd1 << shift) - 64'd1);
   assign tick = (phase_q == lim) && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        phase_q <= '0;
      else if (clr)      phase_q <= '0;
      else if (tick)     phase_q <= '0;
      else               phase_q <= phase_q + PRESC_W'(1);
   end
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] init_val,
   input  logic             tick,
   input  logic             periodic,
   output logic [CNT_W-1:0] cur,
   output logic             expire
);
   logic [CNT_W-1:0] cur_q;

   assign cur    = cur_q;
   assign expire = tick && !load && (cur_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cur_q <= '0;
      else if (load)              cur_q <= load_val;
      else if (expire)            cur_q <= periodic ? init_val : '0;
      else if (tick && cur_q != '0) cur_q <= cur_q - CNT_W'(1);
   end
endmodule

// File: rtl/lt_lvt_bank.sv
module lt_lvt_bank import lt_pkg::*; #(
   parameter int NUM_LVT = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ena_wr,
   input  logic [NUM_LVT-1:0]               lvt_wr,
   input  logic [REG_W-1:0]                 wr_data,
   output logic [NUM_LVT-1:0][REG_W-1:0]    lvt,
   output logic [ENA_W-1:0]                 ena,
   output logic                             sw_en
);
   logic [ENA_W-1:0] ena_q;
   logic             disable_now;

   assign ena         = ena_q;
   assign sw_en       = ena_q[ENA_BIT];
   assign disable_now = ena_wr && !wr_data[ENA_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ena_q <= ENA_W'(9'h0FF);
      else if (ena_wr) ena_q <= wr_data[ENA_W-1:0];
   end

   generate
      for (genvar i = 0; i < NUM_LVT; i++) begin : g_ent
         localparam logic [REG_W-1:0] KEEP = (i == 0) ? TMR_KEEP : OTH_KEEP;
         logic [REG_W-1:0] ent_q;
         assign lvt[i] = ent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           ent_q <= MASK_ONLY;
            else if (lvt_wr[i])   ent_q <= (wr_data & KEEP) | (sw_en ? '0 : MASK_ONLY);
            else if (disable_now) ent_q <= ent_q | MASK_ONLY;
         end
      end
   endgenerate
endmodule

// File: rtl/lt_req.sv
module lt_req import lt_pkg::*; #(
   parameter int PEND_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             ack,
   input  logic [VEC_W-1:0] vec_in,
   output logic             req,
   output logic [VEC_W-1:0] vec
);
   logic              req_q, req_mid, req_n;
   logic [PEND_W-1:0] pend_q, pend_n;
   logic [VEC_W-1:0]  vec_q;

   assign req = req_q;
   assign vec = vec_q;

   always_comb begin
      req_mid = req_q;
      pend_n  = pend_q;
      if (ack && req_q) begin
         if (pend_q != '0) pend_n = pend_q - PEND_W'(1);
         else              req_mid = 1'b0;
      end
      req_n = req_mid;
      if (fire) begin
         if (req_mid) begin
            if (pend_n != '1) pend_n = pend_n + PEND_W'(1);
         end else begin
            req_n = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_q <= '0;
         vec_q  <= '0;
      end else begin
         req_q  <= req_n;
         pend_q <= pend_n;
         if (fire && !req_mid) vec_q <= vec_in;
      end
   end
endmodule

// File: rtl/lt_timer.sv
module lt_timer import lt_pkg::*; #(
   parameter int CNT_W   = 32,
   parameter int NUM_LVT = 4,
   parameter int PEND_W  = 4,
   localparam int SEL_W  = $clog2(LVT_BASE + NUM_LVT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [REG_W-1:0] rd_data,
   input  logic             ack,
   output logic             req_valid,
   output logic [VEC_W-1:0] req_vector
);
   generate
      if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt
         $error("lt_timer: CNT_W out of range");
      end
      if (NUM_LVT < 1) begin : g_bad_lvt
         $error("lt_timer: NUM_LVT must be at least 1");
      end
      if (PEND_W < 1) begin : g_bad_pend
         $error("lt_timer: PEND_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]             init_q, cur_q;
   logic [DIVCFG_W-1:0]          div_q;
   logic                         wr_init, wr_div, wr_ena;
   logic [NUM_LVT-1:0]           lvt_wr;
   logic [NUM_LVT-1:0]           lvt_mask_v;
   logic [NUM_LVT-1:0][REG_W-1:0] lvt;
   logic [ENA_W-1:0]             ena;
   logic                         sw_en, tick, expire, fire;

   assign wr_init = wr_en && (wr_sel == SEL_W'(SEL_INIT));
   assign wr_div  = wr_en && (wr_sel == SEL_W'(SEL_DIV));
   assign wr_ena  = wr_en && (wr_sel == SEL_W'(SEL_ENA));

   generate
      for (genvar i = 0; i < NUM_LVT; i++) begin : g_sel
         assign lvt_wr[i]     = wr_en && (wr_sel == SEL_W'(LVT_BASE + i));
         assign lvt_mask_v[i] = lvt[i][MASK_BIT];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= '0;
         div_q  <= '0;
      end else begin
         if (wr_init) init_q <= wr_data[CNT_W-1:0];
         if (wr_div)  div_q  <= wr_data[DIVCFG_W-1:0] & DIV_KEEP;
      end
   end

   lt_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_init || wr_div),
      .shift (div_shift(div_q)),
      .tick  (tick)
   );

   lt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_init),
      .load_val (wr_data[CNT_W-1:0]),
      .init_val (init_q),
      .tick     (tick),
      .periodic (lvt[0][PER_BIT]),
      .cur      (cur_q),
      .expire   (expire)
   );

   lt_lvt_bank #(.NUM_LVT(NUM_LVT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ena_wr  (wr_ena),
      .lvt_wr  (lvt_wr),
      .wr_data (wr_data),
      .lvt     (lvt),
      .ena     (ena),
      .sw_en   (sw_en)
   );

   assign fire = expire && !lvt[0][MASK_BIT] && sw_en;

   lt_req #(.PEND_W(PEND_W)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .ack    (ack),
      .vec_in (lvt[0][VEC_W-1:0]),
      .req    (req_valid),
      .vec    (req_vector)
   );

   always_comb begin
      rd_data = '0;
      if (rd_sel == SEL_W'(SEL_INIT))     rd_data = REG_W'(init_q);
      else if (rd_sel == SEL_W'(SEL_CUR)) rd_data = REG_W'(cur_q);
      else if (rd_sel == SEL_W'(SEL_DIV)) rd_data = REG_W'(div_q);
      else if (rd_sel == SEL_W'(SEL_ENA)) rd_data = REG_W'(ena);
      else begin
         for (int i = 0; i < NUM_LVT; i++)
            if (rd_sel == SEL_W'(LVT_BASE + i)) rd_data = lvt[i];
      end
   end
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk import lt_pkg::*; #(
   parameter int CNT_W   = 32,
   parameter int NUM_LVT = 4,
   parameter int SEL_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [SEL_W-1:0]   wr_sel,
   input logic [CNT_W-1:0]   wr_cnt,
   input logic               ack,
   input logic               req_valid,
   input logic [CNT_W-1:0]   cur,
   input logic               sw_en,
   input logic               tmr_mask,
   input logic [NUM_LVT-1:0] masks
);
   logic init_wr;
   assign init_wr = wr_en && (wr_sel == SEL_W'(SEL_INIT));

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !ack |=> req_valid);

   // R3
   init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_wr |=> cur == $past(wr_cnt));

   // R11
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == '0) && !init_wr |=> cur == '0);

   // R10
   dis_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |-> &masks);

   // R8
   fire_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(!tmr_mask && sw_en));
endmodule

bind lt_timer lt_timer_chk #(.CNT_W(CNT_W), .NUM_LVT(NUM_LVT), .SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_cnt    (wr_data[CNT_W-1:0]),
   .ack       (ack),
   .req_valid (req_valid),
   .cur       (cur_q),
   .sw_en     (sw_en),
   .tmr_mask  (lvt[0][16]),
   .masks     (lvt_mask_v)
);

// File: tb/lt_timer_tb.sv
module lt_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        ack_tb = 1'b0;
   logic        mon_ack = 1'b0;
   logic        req_valid;
   logic [7:0]  req_vector;

   int n_chk = 0;
   int n_fail = 0;
   int edge_n = 0;
   bit auto_ack = 1'b1;
   bit done = 1'b0;

   typedef struct { int e; logic [7:0] v; } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;
   always @(posedge clk) edge_n <= edge_n + 1;

   lt_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .rd_sel     (rd_sel),
      .rd_data    (rd_data),
      .ack        (ack_tb | mon_ack),
      .req_valid  (req_valid),
      .req_vector (req_vector)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
      end
   endtask

   task automatic push(input int e, input logic [7:0] v);
      exp_t it;
      it.e = e; it.v = v;
      exp_q.push_back(it);
   endtask

   // monitor: pops the scoreboard on every rising request
   logic req_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && req_valid && !req_prev) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R8: actual unexpected request at edge %0d vector 0x%02h, expected none", edge_n, req_vector);
         end else begin
            exp_t it;
            it = exp_q.pop_front();
            check("R6 request edge", edge_n, it.e);
            check("R6 request vector", {24'd0, req_vector}, {24'd0, it.v});
         end
      end
      req_prev = req_valid;
      mon_ack  = auto_ack && req_valid && !mon_ack;
   end

   task automatic wr(input logic [2:0] sel, input logic [31:0] d, output int e);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      e = edge_n;
   endtask

   task automatic rd(input string tag, input logic [2:0] sel, input logic [31:0] expv);
      rd_sel = sel;
      #1;
      check(tag, rd_data, expv);
   endtask

   task automatic wait_edge(input int t);
      while (edge_n < t) @(negedge clk);
   endtask

   task automatic ack_pulse();
      ack_tb = 1'b1;
      @(negedge clk);
      ack_tb = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int e, w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd("R1 enable", 3'd3, 32'h0FF);
      rd("R1 entry0", 3'd4, 32'h1_0000);
      rd("R1 entry3", 3'd7, 32'h1_0000);
      rd("R1 current", 3'd1, 32'h0);
      check("R1 req", {31'd0, req_valid}, 32'd0);

      // R9 timer entry bits, disabled so mask forced
      wr(3'd4, 32'hFFFF_FFFF, e);
      rd("R9 timer keep", 3'd4, 32'h0003_10FF);
      // R10 nine bits, enabling unmasks nothing
      wr(3'd3, 32'hFFFF_FFFF, e);
      rd("R10 enable bits", 3'd3, 32'h1FF);
      rd("R10 still masked", 3'd4, 32'h0003_10FF);
      wr(3'd4, 32'hFFFE_EF00, e);
      rd("R9 timer cleared", 3'd4, 32'h0002_0000);
      wr(3'd5, 32'hFFFF_FFFF, e);
      rd("R9 other keep", 3'd5, 32'h0001_17FF);

      // R2 divide by 1, R5 one-shot
      wr(3'd2, 32'hB, e);
      rd("R2 div readback", 3'd2, 32'hB);
      wr(3'd4, 32'h41, e);
      wr(3'd0, 32'd10, e);
      push(e + 10, 8'h41);
      rd("R3 load", 3'd1, 32'd10);
      wait_edge(e + 3);
      rd("R2 div1 count", 3'd1, 32'd7);
      wait_edge(e + 40);
      rd("R5 one-shot zero", 3'd1, 32'd0);
      check("R5 req dropped", {31'd0, req_valid}, 32'd0);

      // R2 divide by 2, bit 2 dropped
      wr(3'd2, 32'h4, e);
      rd("R2 bit2 dropped", 3'd2, 32'h0);
      wr(3'd0, 32'd5, e);
      push(e + 10, 8'h41);
      wait_edge(e + 4);
      rd("R2 div2 count", 3'd1, 32'd3);
      wait_edge(e + 30);

      // R2 divide by 16
      wr(3'd2, 32'h3, e);
      wr(3'd0, 32'd3, e);
      push(e + 48, 8'h41);
      wait_edge(e + 15);
      rd("R2 div16 before", 3'd1, 32'd3);
      wait_edge(e + 16);
      rd("R2 div16 tick", 3'd1, 32'd2);
      wait_edge(e + 60);

      // R2 divide by 32
      wr(3'd2, 32'hC, e);
      rd("R2 div32 readback", 3'd2, 32'h8);
      wr(3'd0, 32'd2, e);
      push(e + 64, 8'h41);
      wait_edge(e + 31);
      rd("R2 div32 before", 3'd1, 32'd2);
      wait_edge(e + 32);
      rd("R2 div32 tick", 3'd1, 32'd1);
      wait_edge(e + 80);

      // R4 periodic, R11 stop
      wr(3'd2, 32'hB, e);
      wr(3'd4, 32'h2_0055, e);
      wr(3'd0, 32'd4, e);
      push(e + 4, 8'h55);
      push(e + 8, 8'h55);
      push(e + 12, 8'h55);
      wait_edge(e + 4);
      rd("R4 reload", 3'd1, 32'd4);
      wait_edge(e + 13);
      wr(3'd0, 32'd0, w);
      rd("R11 stopped", 3'd1, 32'd0);
      wait_edge(w + 20);
      rd("R11 stays stopped", 3'd1, 32'd0);
      check("R11 no request", {31'd0, req_valid}, 32'd0);

      // R12 divide write clears prescaler phase
      wr(3'd2, 32'h0, e);
      wr(3'd0, 32'd10, e);
      wr(3'd2, 32'h0, w);
      wait_edge(e + 2);
      rd("R12 no tick yet", 3'd1, 32'd10);
      wait_edge(e + 3);
      rd("R12 tick after clear", 3'd1, 32'd9);
      wr(3'd0, 32'd0, e);

      // R8 masked timer counts but does not request
      wr(3'd2, 32'hB, e);
      wr(3'd4, 32'h1_0077, e);
      wr(3'd0, 32'd3, e);
      wait_edge(e + 6);
      rd("R8 counted down", 3'd1, 32'd0);
      check("R8 masked no request", {31'd0, req_valid}, 32'd0);

      // R10 disable masks all entries and forces writes masked
      wr(3'd4, 32'h77, e);
      wr(3'd5, 32'h0, e);
      wr(3'd3, 32'h0FF, e);
      rd("R10 timer masked", 3'd4, 32'h1_0077);
      rd("R10 entry1 masked", 3'd5, 32'h1_0000);
      wr(3'd6, 32'h33, e);
      rd("R10 forced mask", 3'd6, 32'h1_0033);
      wr(3'd0, 32'd3, e);
      wait_edge(e + 6);
      check("R8 disabled no request", {31'd0, req_valid}, 32'd0);
      wr(3'd3, 32'h1FF, e);
      rd("R10 enable keeps mask", 3'd4, 32'h1_0077);

      // R7 pending count
      auto_ack = 1'b0;
      wr(3'd4, 32'h2_0066, e);
      wr(3'd0, 32'd2, e);
      push(e + 2, 8'h66);
      wait_edge(e + 6);
      wr(3'd0, 32'd0, w);
      check("R7 req held", {31'd0, req_valid}, 32'd1);
      check("R7 vector", {24'd0, req_vector}, 32'h66);
      ack_pulse();
      check("R7 after ack 1", {31'd0, req_valid}, 32'd1);
      ack_pulse();
      check("R7 after ack 2", {31'd0, req_valid}, 32'd1);
      ack_pulse();
      check("R7 after ack 3", {31'd0, req_valid}, 32'd0);

      repeat (5) @(negedge clk);
      check("R6 scoreboard drained", exp_q.size(), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule